// File: doc/BRIEF.md
# Byte-Merge Partial-Write Datapath

This block is the 32-bit steering path that sits around an error-correction core. It holds the word arriving from the system side and the word and checkbits arriving from memory. An optional pipeline stage follows the choice between corrected and raw memory data. For each byte, a multiplexer then picks either the old memory byte or the new system byte. The result is a merged word, sent back toward memory and into an external checkbit generator. This supports read-modify-write partial stores and correction write-backs.

The correction logic itself sits outside. The latched memory word and checkbits go out to an external corrector, and the corrected word comes back on a plain input. Both buses are modelled as a data output plus an active-high drive enable, so the block has no internal tri-state. The system side also returns one parity bit per byte, and that parity can be set to even or odd.

All three holding stages behave like level-sensitive latches built from a clocked register. The stage output follows its input in the same cycle while it is open, and it keeps the value captured at the last clock edge while it is closed. A synchronous active-low reset clears the held values.

Top module: `bm_datapath`

## Requirements
- R1: While `sys_capture` is 1 the system stage passes `sys_din` through in the same cycle. While it is 0 the stage keeps the value present at the last rising clock edge at which it was open.
- R2: While `mem_capture` is 1 the memory stage passes `mem_din` to `mem_word_lat` and `chk_din` to `chk_lat` in the same cycle. While it is 0 both keep their last captured values.
- R3: The pipeline stage has the opposite polarity. It is open while `pipe_hold` is 0, and while `pipe_hold` is 1 it keeps the value present at the last rising edge at which it was open.
- R4: For byte n (bits 8n+7:8n), `byte_sel[n]`=1 puts the pipeline-stage byte on `merge_word` and `mem_dout`, and `byte_sel[n]`=0 puts the system-stage byte there instead.
- R5: The pipeline stage input is `corr_data` when `mode[1:0]` is 2'b11, whatever the value of `mode[2]`. In all other modes it is `mem_word_lat`. The stage output appears on `sys_dout`.
- R6: `sys_drv[n]` and `par_drv[n]` are 1 only when `sys_oe_n` is 0 and `byte_sel[n]` is 1.
- R7: `par_dout[n]` makes the count of ones in {`par_dout[n]`, `sys_dout` byte n} even when `parity_odd` is 0, and odd when it is 1.
- R8: `mem_drv` is 1 exactly when `mem_oe_n` is 0.
- R9: A rising edge with `rst_n` at 0 clears the held value of every stage to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_din | input | 32 | New data from the system bus |
| sys_capture | input | 1 | System stage open while 1 |
| mem_din | input | 32 | Data word read from memory |
| chk_din | input | 8 | Checkbits read from memory |
| mem_capture | input | 1 | Memory stage open while 1 |
| pipe_hold | input | 1 | Pipeline stage holds while 1 |
| corr_data | input | 32 | Corrected word from the external corrector |
| mode | input | 3 | Mode field; 2'b11 in the low bits selects corrected data |
| parity_odd | input | 1 | 0 for even byte parity, 1 for odd |
| sys_oe_n | input | 1 | Active-low system output enable |
| mem_oe_n | input | 1 | Active-low memory output enable |
| byte_sel | input | 4 | Per-byte select: 1 keeps the old memory byte, 0 takes the new byte |
| sys_dout | output | 32 | Data toward the system bus |
| sys_drv | output | 4 | Per-byte system bus drive enable |
| par_dout | output | 4 | Per-byte parity toward the system bus |
| par_drv | output | 4 | Per-byte parity drive enable |
| mem_dout | output | 32 | Merged word toward the memory bus |
| mem_drv | output | 1 | Memory bus drive enable |
| merge_word | output | 32 | Merged word feeding the checkbit generator |
| mem_word_lat | output | 32 | Latched memory word toward the corrector |
| chk_lat | output | 8 | Latched checkbits toward the corrector |

## Verification
The bench drives all sixteen byte-select patterns with distinct byte values and compares every byte against a behavioural model. A swapped lane mapping or an inverted select would therefore put the wrong byte into the merged word. It opens and closes each stage across clock edges, including mode changes while the pipeline holds. A stage with its polarity reversed, or one that samples at the wrong edge, would show stale or too-early data. Parity is checked in both polarities over random bytes, and both output enables are checked in every combination with the byte selects. An inverted parity sense or an enable that ignores its byte select shows up at once.

// File: rtl/bm_pkg.sv
// Shared sizes and helpers for the byte-merge datapath.
package bm_pkg;
    localparam int LANES    = 4;
    localparam int LANE_W   = 8;
    localparam int WORD_W   = LANES * LANE_W;
    localparam int CHK_W    = 8;
    localparam int MODE_W   = 3;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [WORD_W-1:0] word_t;

    // True when the mode field asks for corrected data on the output path.
    function automatic logic use_corrected(input logic [MODE_W-1:0] m);
        return (m[1:0] == 2'b11);
    endfunction
endpackage

// File: rtl/bm_latch.sv
// Latch-like holding stage built from one clocked register.
// While open, q follows d in the same cycle; while closed, q keeps the value
// registered at the last rising edge it was open. OPEN_HIGH picks whether
// en=1 or en=0 opens the stage. Assumes a single clock and synchronous
// active-low reset that clears the held value.
module bm_latch #(
    parameter int W         = 32,
    parameter bit OPEN_HIGH = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic         is_open;
    logic [W-1:0] held;

    generate
        if (OPEN_HIGH) begin : g_high
            assign is_open = en;
        end else begin : g_low
            assign is_open = !en;
        end
    endgenerate

    // Pass-through while open, otherwise present the held copy.
    always_comb begin
        q = is_open ? d : held;
    end

    // Record the visible value each edge so a close keeps the last open value.
    always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else        held <= q;
    end

    // R1 R2 R3: a stage closed on two successive cycles keeps its output
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_open && $past(!is_open) && $past(rst_n)) |-> $stable(q));
endmodule

// File: rtl/bm_lane.sv
// One byte lane: chooses old memory byte or new system byte for the merged
// word, computes the byte's parity with selectable sense, and forms the
// per-byte system drive enable. Purely combinational.
module bm_lane
    import bm_pkg::*;
(
    input  lane_t old_byte,
    input  lane_t new_byte,
    input  logic  keep_old,
    input  logic  parity_odd,
    input  logic  sys_oe_n,
    output lane_t merged,
    output logic  par,
    output logic  drv
);
    // Byte steering, parity and drive enable for this lane.
    always_comb begin
        merged = keep_old ? old_byte : new_byte;
        par    = (^old_byte) ^ parity_odd;
        drv    = keep_old && !sys_oe_n;
    end
endmodule

// File: rtl/bm_datapath.sv
// Top of the byte-merge partial-write datapath. Holds the system word, the
// memory word with checkbits, and an optional pipelined copy of the chosen
// (corrected or raw) memory word. Builds the per-byte merged word toward
// memory and the checkbit generator, per-byte parity toward the system side,
// and drive enables for both buses. Assumes the corrector is external and
// returns corr_data combinationally from mem_word_lat/chk_lat.
module bm_datapath
    import bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       sys_din,
    input  logic              sys_capture,
    input  logic [31:0]       mem_din,
    input  logic [7:0]        chk_din,
    input  logic              mem_capture,
    input  logic              pipe_hold,
    input  logic [31:0]       corr_data,
    input  logic [2:0]        mode,
    input  logic              parity_odd,
    input  logic              sys_oe_n,
    input  logic              mem_oe_n,
    input  logic [3:0]        byte_sel,
    output logic [31:0]       sys_dout,
    output logic [3:0]        sys_drv,
    output logic [3:0]        par_dout,
    output logic [3:0]        par_drv,
    output logic [31:0]       mem_dout,
    output logic              mem_drv,
    output logic [31:0]       merge_word,
    output logic [31:0]       mem_word_lat,
    output logic [7:0]        chk_lat
);
    word_t                   sys_word;
    word_t                   pick_word;
    word_t                   pipe_word;
    logic [WORD_W+CHK_W-1:0] mem_pack;
    word_t                   merged_all;

    bm_latch #(.W(WORD_W), .OPEN_HIGH(1'b1)) u_sys_stage (
        .clk(clk), .rst_n(rst_n), .en(sys_capture), .d(sys_din), .q(sys_word)
    );

    bm_latch #(.W(WORD_W + CHK_W), .OPEN_HIGH(1'b1)) u_mem_stage (
        .clk(clk), .rst_n(rst_n), .en(mem_capture),
        .d({chk_din, mem_din}), .q(mem_pack)
    );

    // Choose corrected or raw memory data for the output and merge path.
    always_comb begin
        pick_word = use_corrected(mode) ? corr_data : mem_pack[WORD_W-1:0];
    end

    bm_latch #(.W(WORD_W), .OPEN_HIGH(1'b0)) u_pipe_stage (
        .clk(clk), .rst_n(rst_n), .en(pipe_hold), .d(pick_word), .q(pipe_word)
    );

    genvar n;
    generate
        for (n = 0; n < LANES; n++) begin : g_lane
            bm_lane u_lane (
                .old_byte  (pipe_word[n*LANE_W +: LANE_W]),
                .new_byte  (sys_word[n*LANE_W +: LANE_W]),
                .keep_old  (byte_sel[n]),
                .parity_odd(parity_odd),
                .sys_oe_n  (sys_oe_n),
                .merged    (merged_all[n*LANE_W +: LANE_W]),
                .par       (par_dout[n]),
                .drv       (sys_drv[n])
            );

            // R7: driven parity bit plus its byte has the selected sense
            parity_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
                par_drv[n] |-> ((^{par_dout[n], sys_dout[n*LANE_W +: LANE_W]}) == parity_odd));

            // R4: a cleared select takes the system stage byte
            merge_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !byte_sel[n] |-> (merge_word[n*LANE_W +: LANE_W] == sys_word[n*LANE_W +: LANE_W]));
        end
    endgenerate

    // Drive the output ports from the internal nets.
    always_comb begin
        sys_dout     = pipe_word;
        par_drv      = sys_drv;
        merge_word   = merged_all;
        mem_dout     = merged_all;
        mem_drv      = !mem_oe_n;
        mem_word_lat = mem_pack[WORD_W-1:0];
        chk_lat      = mem_pack[WORD_W +: CHK_W];
    end

    // R5: with the pipeline open and corrected mode, the output is corr_data
    corr_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_hold && use_corrected(mode)) |-> (sys_dout == corr_data));

    // R6: a system drive enable implies an active output enable
    sys_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|sys_drv) |-> !sys_oe_n);
endmodule

// File: tb/bm_datapath_test.sv
module bm_datapath_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] sys_din, mem_din, corr_data;
    logic [7:0]  chk_din;
    logic        sys_capture, mem_capture, pipe_hold, parity_odd, sys_oe_n, mem_oe_n;
    logic [2:0]  mode;
    logic [3:0]  byte_sel;
    logic [31:0] sys_dout, mem_dout, merge_word, mem_word_lat;
    logic [3:0]  sys_drv, par_dout, par_drv;
    logic        mem_drv;
    logic [7:0]  chk_lat;

    int checks = 0;
    int failures = 0;

    // behavioural model state: held values of the three stages
    logic [31:0] h_sys, h_mem, h_pipe;
    logic [7:0]  h_chk;

    bm_datapath uut (.*);

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected visible values from inputs and model state
    task automatic compare();
        logic [31:0] e_sys, e_mem, e_pick, e_pipe, e_merge;
        logic [7:0]  e_chk;
        logic [3:0]  e_drv, e_par;
        e_sys  = sys_capture ? sys_din : h_sys;
        e_mem  = mem_capture ? mem_din : h_mem;
        e_chk  = mem_capture ? chk_din : h_chk;
        e_pick = (mode[1] && mode[0]) ? corr_data : e_mem;
        e_pipe = pipe_hold ? h_pipe : e_pick;
        for (int b = 0; b < 4; b++) begin
            int ones;
            e_merge[b*8 +: 8] = byte_sel[b] ? e_pipe[b*8 +: 8] : e_sys[b*8 +: 8];
            e_drv[b] = (sys_oe_n == 1'b0) && (byte_sel[b] == 1'b1);
            ones = 0;
            for (int k = 0; k < 8; k++) if (e_pipe[b*8+k]) ones++;
            e_par[b] = ((ones % 2) == 1) ? !parity_odd : parity_odd;
        end
        check("R2", "mem_word_lat", mem_word_lat, e_mem);
        check("R2", "chk_lat", chk_lat, e_chk);
        check("R3/R5", "sys_dout", sys_dout, e_pipe);
        check("R1/R4", "merge_word", merge_word, e_merge);
        check("R4", "mem_dout", mem_dout, e_merge);
        check("R6", "sys_drv", sys_drv, e_drv);
        check("R6", "par_drv", par_drv, e_drv);
        check("R7", "par_dout", par_dout, e_par);
        check("R8", "mem_drv", mem_drv, !mem_oe_n);
        // model update at the coming edge
        @(posedge clk);
        if (!rst_n) begin
            h_sys = 0; h_mem = 0; h_chk = 0; h_pipe = 0;
        end else begin
            h_sys = e_sys; h_mem = e_mem; h_chk = e_chk; h_pipe = e_pipe;
        end
    endtask

    // inputs change at the falling edge, checks 5 ns later
    task automatic step();
        #5;
        compare();
        @(negedge clk);
    endtask

    task automatic rand_inputs();
        sys_din = $urandom; mem_din = $urandom; corr_data = $urandom;
        chk_din = 8'($urandom); mode = 3'($urandom);
        sys_capture = 1'($urandom); mem_capture = 1'($urandom);
        pipe_hold = 1'($urandom); parity_odd = 1'($urandom);
        sys_oe_n = 1'($urandom); mem_oe_n = 1'($urandom);
        byte_sel = 4'($urandom);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        h_sys = 0; h_mem = 0; h_chk = 0; h_pipe = 0;
        rst_n = 1'b0;
        rand_inputs();
        sys_capture = 0; mem_capture = 0; pipe_hold = 1;
        @(negedge clk);
        // R9: reset clears all held values; closed stages then show zero
        step(); step();
        check("R9", "reset sys_dout", sys_dout, 32'h0);
        check("R9", "reset mem_word_lat", mem_word_lat, 32'h0);
        check("R9", "reset chk_lat", chk_lat, 8'h0);
        rst_n = 1'b1;

        // R1 R2: open then close with distinct lane bytes
        sys_din = 32'h44332211; mem_din = 32'hDDCCBBAA; chk_din = 8'h5A;
        sys_capture = 1; mem_capture = 1; pipe_hold = 0; mode = 3'b000;
        sys_oe_n = 0; mem_oe_n = 0; parity_odd = 0;
        step();
        sys_capture = 0; mem_capture = 0; pipe_hold = 1;
        sys_din = 32'h0; mem_din = 32'h0; chk_din = 8'h0;
        // R4: every select pattern
        for (int s = 0; s < 16; s++) begin
            byte_sel = 4'(s); parity_odd = s[0];
            step();
        end
        // R5 R3: corrected mode with pipeline open, then held across mode change
        pipe_hold = 0; mode = 3'b111; corr_data = 32'h12345678;
        step();
        pipe_hold = 1; mode = 3'b011; corr_data = 32'h0;
        step(); step();
        mode = 3'b100; pipe_hold = 0;
        step();
        // random traffic
        for (int i = 0; i < 400; i++) begin
            rand_inputs();
            rst_n = (i % 97 == 50) ? 1'b0 : 1'b1;
            step();
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule